// File: doc/BRIEF.md
# Video shift and pixel clock controller

This block produces the two clocks that a video back end needs from one fast timing clock. The video clock (`vclk_o`) is a divided copy of the dot rate and goes to the external timing logic that makes blanking and sync. The shift clock (`sclk_o`) drives the serial port of a video memory and runs 1:1 with the video clock. The blanking input is captured only on the edge at which the video clock falls. All gating uses this captured value. The shift clock stops cleanly while blanking is active: it never cuts a high phase short and never makes a runt pulse.

An optional split-transfer mode lets a rising edge on a flag input create one extra shift pulse of guaranteed minimum width during blanking. That pulse takes the place of the first shift pulse after blanking ends, so no data word is shifted twice. The captured blank is also delayed through a pipeline so that it lines up with the pixel data path. A one-cycle latch strobe marks every shift-clock rising edge that falls outside the delayed blanking window.

The whole design is synchronous to `clk`, which runs at twice the dot rate, so a dot period is two `clk` cycles. Both output clocks are register outputs.

Top module: `vid_shift_clk_ctrl`

## Requirements
- R1: While `rst_n` is low and just after it is released, `vclk_o` is 1, `sclk_o` is 0, `blank_dly_n_o` is 0 and `pix_strobe_o` is 0.
- R2: For `vdiv_sel` values 0 to 5, `vclk_o` has a period of 2^(`vdiv_sel`+1) `clk` cycles with 2^`vdiv_sel` cycles high. For values 6 and 7, `vclk_o` is held at 1.
- R3: `blank_n` (active low) is captured only at the `clk` edge where `vclk_o` goes from 1 to 0. A blank pulse that starts and ends between two such edges has no effect on `sclk_o` or `blank_dly_n_o`.
- R4: While the captured blank is high, `sclk_o` rises at the same edge as `vclk_o` and falls at the same edge as `vclk_o`.
- R5: Once `sclk_o` is high in a normal cycle, it stays high until `vclk_o` falls, even if blanking becomes active in between.
- R6: While the captured blank is low, `sclk_o` stays 0, except for a split pulse.
- R7: With `split_en` = 1, the captured blank low and `sclk_o` low, a rising edge of `split_flag` makes `sclk_o` go high at the third `clk` edge after the flag rises. It stays high for exactly SPLIT_MIN cycles (default 2).
- R8: At most one split pulse is produced per blanking interval. Further flag edges in the same interval are ignored.
- R9: After a split pulse, the first `vclk_o` rising edge with the captured blank high produces no `sclk_o` pulse. The next rising edge does.
- R10: With `split_en` = 0, `split_flag` has no effect. The first `vclk_o` rise after blanking then produces an `sclk_o` pulse.
- R11: `blank_dly_n_o` equals the captured blank delayed by PIPE_DEPTH (default 3) `clk` cycles.
- R12: `pix_strobe_o` is high for exactly one cycle at each `sclk_o` rising edge for which `blank_dly_n_o` was 1 just before that edge, and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock at twice the dot rate |
| rst_n | input | 1 | Active-low synchronous reset |
| blank_n | input | 1 | Blanking input, low means blank |
| split_flag | input | 1 | Asynchronous split-transfer request flag |
| split_en | input | 1 | Enables split-transfer pulses |
| vdiv_sel | input | 3 | Video clock divide select (0-5 divide, 6-7 hold high) |
| vclk_o | output | 1 | Divided video clock |
| sclk_o | output | 1 | Gated shift clock for the memory serial port |
| blank_dly_n_o | output | 1 | Captured blank delayed to align with pixel data |
| pix_strobe_o | output | 1 | One-cycle pixel latch strobe |

## Verification
The divider is exercised at the smallest, a middle and the largest ratio and in hold mode, which separates off-by-one counting from a wrong encoding. Blank is raised in the middle of a shift high phase, to catch truncation, and as a short pulse between two video clock falls, to catch a raw-pin sample in place of a captured one. Split transfer is tried with a single edge, with a repeated edge in the same interval, and with the mode disabled. Together these show the exact pulse timing and width, that the pulse fires only once, and that the first shift pulse after blanking is suppressed only when a split pulse has occurred.

// File: rtl/vsc_pkg.sv
package vsc_pkg;

  localparam int SEL_W = 3;

  // Number of timing-clock cycles in one video clock half period.
  function automatic int unsigned half_cycles(input logic [SEL_W-1:0] sel);
    return 32'd1 << sel;
  endfunction

  // A select value above the largest divide exponent parks the clock high.
  function automatic logic sel_holds(input logic [SEL_W-1:0] sel, input int log_max);
    return int'({29'd0, sel}) > log_max;
  endfunction

endpackage

// File: rtl/vsc_vclk_div.sv
module vsc_vclk_div
  import vsc_pkg::*;
#(
  parameter int DIV_LOG_MAX = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel,
  output logic             vclk_o,
  output logic             rise_nxt_o,
  output logic             fall_nxt_o,
  output logic             hold_o
);

  localparam int CNT_W = (DIV_LOG_MAX > 0) ? DIV_LOG_MAX : 1;

  logic [CNT_W-1:0] cnt_q;
  logic             vclk_q;
  logic             toggle;

  always_comb begin
    hold_o = sel_holds(sel, DIV_LOG_MAX);
    toggle = !hold_o && (int'({1'b0, cnt_q}) >= int'(half_cycles(sel)) - 1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vclk_q <= 1'b1;
      cnt_q  <= '0;
    end else if (hold_o) begin
      vclk_q <= 1'b1;
      cnt_q  <= '0;
    end else if (toggle) begin
      vclk_q <= ~vclk_q;
      cnt_q  <= '0;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign vclk_o     = vclk_q;
  assign rise_nxt_o = toggle & ~vclk_q;
  assign fall_nxt_o = toggle &  vclk_q;

endmodule

// File: rtl/vsc_blank_pipe.sv
module vsc_blank_pipe #(
  parameter int PIPE_DEPTH = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic blank_n,
  input  logic sample_i,
  output logic blank_s_o,
  output logic blank_dly_o
);

  logic                  blank_s_q;
  logic [PIPE_DEPTH-1:0] dly_q;

  always_ff @(posedge clk) begin
    if (!rst_n)        blank_s_q <= 1'b0;
    else if (sample_i) blank_s_q <= blank_n;
  end

  for (genvar g = 0; g < PIPE_DEPTH; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rst_n) dly_q[g] <= 1'b0;
        else        dly_q[g] <= blank_s_q;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rst_n) dly_q[g] <= 1'b0;
        else        dly_q[g] <= dly_q[g-1];
      end
    end
  end

  assign blank_s_o   = blank_s_q;
  assign blank_dly_o = dly_q[PIPE_DEPTH-1];

endmodule

// File: rtl/vsc_sclk_gate.sv
module vsc_sclk_gate #(
  parameter int SPLIT_MIN = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rise_nxt_i,
  input  logic fall_nxt_i,
  input  logic hold_i,
  input  logic blank_s_i,
  input  logic blank_dly_i,
  input  logic split_flag,
  input  logic split_en,
  output logic sclk_o,
  output logic pix_strobe_o,
  output logic inject_o,
  output logic split_busy_o
);

  localparam int SC_W = $clog2(SPLIT_MIN + 1);
  localparam logic [SC_W-1:0] SC_LOAD = SC_W'(SPLIT_MIN);
  localparam logic [SC_W-1:0] SC_LAST = SC_W'(1);

  logic [2:0]      sync_q;
  logic [SC_W-1:0] cnt_q, cnt_d;
  logic            sclk_q, sclk_d;
  logic            used_q, used_d;
  logic            skip_q, skip_d;
  logic            pix_q;
  logic            flag_edge, norm_rise;

  always_ff @(posedge clk) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[1:0], split_flag};
  end

  assign flag_edge = sync_q[1] & ~sync_q[2];
  assign inject_o  = split_en & flag_edge & ~blank_s_i & ~used_q & ~sclk_q;
  assign norm_rise = rise_nxt_i & blank_s_i & ~sclk_q;

  always_comb begin
    sclk_d = sclk_q;
    cnt_d  = cnt_q;
    used_d = used_q & ~blank_s_i;
    skip_d = skip_q;
    if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
      if (cnt_q == SC_LAST) sclk_d = 1'b0;
    end else if (sclk_q) begin
      if (fall_nxt_i || hold_i) sclk_d = 1'b0;
    end else if (inject_o) begin
      sclk_d = 1'b1;
      cnt_d  = SC_LOAD;
      used_d = 1'b1;
      skip_d = 1'b1;
    end else if (norm_rise) begin
      if (skip_q) skip_d = 1'b0;
      else        sclk_d = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      cnt_q  <= '0;
      used_q <= 1'b0;
      skip_q <= 1'b0;
      pix_q  <= 1'b0;
    end else begin
      sclk_q <= sclk_d;
      cnt_q  <= cnt_d;
      used_q <= used_d;
      skip_q <= skip_d;
      pix_q  <= sclk_d & ~sclk_q & blank_dly_i;
    end
  end

  assign sclk_o       = sclk_q;
  assign pix_strobe_o = pix_q;
  assign split_busy_o = cnt_q != '0;

endmodule

// File: rtl/vid_shift_clk_ctrl.sv
module vid_shift_clk_ctrl
  import vsc_pkg::*;
#(
  parameter int DIV_LOG_MAX = 5,
  parameter int SPLIT_MIN   = 2,
  parameter int PIPE_DEPTH  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             blank_n,
  input  logic             split_flag,
  input  logic             split_en,
  input  logic [SEL_W-1:0] vdiv_sel,
  output logic             vclk_o,
  output logic             sclk_o,
  output logic             blank_dly_n_o,
  output logic             pix_strobe_o
);

  // Internal events, named for the bound checker.
  logic vclk_rise_evt;
  logic vclk_fall_evt;
  logic vdiv_hold;
  logic blank_s;
  logic inject_evt;
  logic split_busy;

  vsc_vclk_div #(.DIV_LOG_MAX(DIV_LOG_MAX)) u_div (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel        (vdiv_sel),
    .vclk_o     (vclk_o),
    .rise_nxt_o (vclk_rise_evt),
    .fall_nxt_o (vclk_fall_evt),
    .hold_o     (vdiv_hold)
  );

  vsc_blank_pipe #(.PIPE_DEPTH(PIPE_DEPTH)) u_pipe (
    .clk         (clk),
    .rst_n       (rst_n),
    .blank_n     (blank_n),
    .sample_i    (vclk_fall_evt),
    .blank_s_o   (blank_s),
    .blank_dly_o (blank_dly_n_o)
  );

  vsc_sclk_gate #(.SPLIT_MIN(SPLIT_MIN)) u_gate (
    .clk          (clk),
    .rst_n        (rst_n),
    .rise_nxt_i   (vclk_rise_evt),
    .fall_nxt_i   (vclk_fall_evt),
    .hold_i       (vdiv_hold),
    .blank_s_i    (blank_s),
    .blank_dly_i  (blank_dly_n_o),
    .split_flag   (split_flag),
    .split_en     (split_en),
    .sclk_o       (sclk_o),
    .pix_strobe_o (pix_strobe_o),
    .inject_o     (inject_evt),
    .split_busy_o (split_busy)
  );

endmodule

// File: rtl/vsc_checker.sv
module vsc_checker (
  input logic clk,
  input logic rst_n,
  input logic vclk_o,
  input logic sclk_o,
  input logic pix_strobe_o,
  input logic blank_s,
  input logic vdiv_hold,
  input logic vclk_fall_evt,
  input logic inject_evt,
  input logic split_busy
);

  logic inj_seen_q;

  always_ff @(posedge clk) begin
    if (!rst_n)          inj_seen_q <= 1'b0;
    else if (blank_s)    inj_seen_q <= 1'b0;
    else if (inject_evt) inj_seen_q <= 1'b1;
  end

  assert_reset_state_R1: assert property (@(posedge clk)
    !rst_n |=> (vclk_o && !sclk_o && !pix_strobe_o));

  assert_hold_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    vdiv_hold |=> vclk_o);

  assert_fall_with_vclk_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_o && !split_busy && vclk_fall_evt) |=> !sclk_o);

  assert_no_truncate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_o && !split_busy && vclk_o && !vclk_fall_evt && !vdiv_hold) |=> sclk_o);

  assert_stopped_in_blank_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!sclk_o && !inject_evt && !blank_s) |=> !sclk_o);

  assert_split_starts_R7: assert property (@(posedge clk) disable iff (!rst_n)
    inject_evt |=> sclk_o);

  assert_split_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    split_busy |-> sclk_o);

  assert_single_split_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (inj_seen_q && !blank_s) |-> !inject_evt);

  assert_strobe_on_rise_R12: assert property (@(posedge clk) disable iff (!rst_n)
    pix_strobe_o |-> (sclk_o && !$past(sclk_o)));

endmodule

bind vid_shift_clk_ctrl vsc_checker u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .vclk_o        (vclk_o),
  .sclk_o        (sclk_o),
  .pix_strobe_o  (pix_strobe_o),
  .blank_s       (blank_s),
  .vdiv_hold     (vdiv_hold),
  .vclk_fall_evt (vclk_fall_evt),
  .inject_evt    (inject_evt),
  .split_busy    (split_busy)
);

// File: tb/tb_vid_shift_clk_ctrl.sv
module tb_vid_shift_clk_ctrl;

  localparam int PIPE = 3;
  localparam int SPLW = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       blank_n = 1'b1;
  logic       split_flag = 1'b0;
  logic       split_en = 1'b0;
  logic [2:0] vdiv_sel = 3'd6;
  logic       vclk_o, sclk_o, blank_dly_n_o, pix_strobe_o;

  int checks = 0;
  int errors = 0;
  logic pv, psc, pdly;

  always #4 clk = ~clk;

  vid_shift_clk_ctrl #(.DIV_LOG_MAX(5), .SPLIT_MIN(SPLW), .PIPE_DEPTH(PIPE)) dut (
    .clk(clk), .rst_n(rst_n), .blank_n(blank_n), .split_flag(split_flag),
    .split_en(split_en), .vdiv_sel(vdiv_sel), .vclk_o(vclk_o), .sclk_o(sclk_o),
    .blank_dly_n_o(blank_dly_n_o), .pix_strobe_o(pix_strobe_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    pv = vclk_o; psc = sclk_o; pdly = blank_dly_n_o;
    @(negedge clk);
  endtask

  task automatic wait_fall();
    do step(); while (!(pv && !vclk_o));
  endtask

  task automatic wait_rise();
    do step(); while (!(!pv && vclk_o));
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R1 vclk in reset", vclk_o, 1);
    chk("R1 sclk in reset", sclk_o, 0);
    rst_n = 1'b1;
    step();
    chk("R1 vclk after reset", vclk_o, 1);
    chk("R1 sclk after reset", sclk_o, 0);
    chk("R1 blank_dly after reset", blank_dly_n_o, 0);
    chk("R1 strobe after reset", pix_strobe_o, 0);
    begin
      int lows = 0;
      for (int i = 0; i < 20; i++) begin step(); if (!vclk_o) lows++; end
      chk("R2 hold mode low samples", lows, 0);
    end
  endtask

  task automatic t_div(input int sel);
    int hi = 0, per = 0;
    vdiv_sel = 3'(sel);
    wait_rise(); wait_rise();
    do begin step(); hi++; end while (vclk_o);
    per = hi;
    do begin step(); per++; end while (!vclk_o);
    chk($sformatf("R2 high length sel=%0d", sel), hi, 1 << sel);
    chk($sformatf("R2 period sel=%0d", sel), per, 2 << sel);
  endtask

  task automatic t_blank_gate();
    int bad = 0;
    vdiv_sel = 3'd2;
    blank_n = 1'b1;
    wait_fall(); wait_rise();
    for (int i = 0; i < 32; i++) begin step(); if (sclk_o != vclk_o) bad++; end
    chk("R4 sclk follows vclk", bad, 0);
    do step(); while (!(!psc && sclk_o));
    blank_n = 1'b0;
    bad = 0;
    while (vclk_o) begin
      if (!sclk_o) bad++;
      step();
    end
    chk("R5 high phase kept", bad, 0);
    chk("R4 sclk falls with vclk", sclk_o, 0);
    bad = 0;
    for (int i = 0; i < 40; i++) begin step(); if (sclk_o) bad++; end
    chk("R6 stopped in blank", bad, 0);
    chk("R11 delayed blank low", blank_dly_n_o, 0);
    blank_n = 1'b1;
    wait_fall();
    for (int k = 1; k <= 4; k++) begin
      step();
      if (k == PIPE - 1) chk("R11 delay not yet", blank_dly_n_o, 0);
      if (k == PIPE)     chk("R11 delay reached", blank_dly_n_o, 1);
    end
    chk("R4 vclk rose", vclk_o, 1);
    chk("R4 sclk resumes", sclk_o, 1);
  endtask

  task automatic t_short_blank();
    int rises = 0, dly_low = 0;
    vdiv_sel = 3'd3;
    wait_fall(); wait_fall();
    step();
    blank_n = 1'b0;
    repeat (3) step();
    blank_n = 1'b1;
    for (int i = 0; i < 40; i++) begin
      step();
      if (!psc && sclk_o) rises++;
      if (!blank_dly_n_o) dly_low++;
    end
    chk("R3 short blank ignored sclk rises", rises, 3);
    chk("R3 short blank ignored delay", dly_low, 0);
  endtask

  task automatic t_strobe();
    int n = 0;
    vdiv_sel = 3'd1;
    blank_n = 1'b1;
    for (int i = 0; i < 64; i++) begin
      if (i == 24) blank_n = 1'b0;
      if (i == 48) blank_n = 1'b1;
      step();
      chk("R12 strobe", pix_strobe_o, int'(sclk_o && !psc && pdly));
      if (pix_strobe_o) n++;
    end
    chk("R12 some strobes seen", int'(n > 4), 1);
  endtask

  task automatic t_split();
    int highs = 0;
    vdiv_sel = 3'd2;
    blank_n = 1'b0;
    wait_fall();
    repeat (8) step();
    split_en = 1'b1;
    split_flag = 1'b1;
    step(); chk("R7 not yet (1)", sclk_o, 0);
    step(); chk("R7 not yet (2)", sclk_o, 0);
    step(); chk("R7 pulse starts", sclk_o, 1);
    step(); chk("R7 pulse held", sclk_o, 1);
    step(); chk("R7 pulse width", sclk_o, 0);
    split_flag = 1'b0;
    repeat (4) step();
    split_flag = 1'b1;
    for (int i = 0; i < 12; i++) begin step(); if (sclk_o) highs++; end
    chk("R8 second edge ignored", highs, 0);
    split_flag = 1'b0;
    blank_n = 1'b1;
    wait_fall();
    wait_rise(); chk("R9 first shift suppressed", sclk_o, 0);
    wait_rise(); chk("R9 second shift runs", sclk_o, 1);
  endtask

  task automatic t_split_off();
    int highs = 0;
    split_en = 1'b0;
    blank_n = 1'b0;
    wait_fall();
    repeat (8) step();
    split_flag = 1'b1;
    for (int i = 0; i < 12; i++) begin
      if (i == 6) split_flag = 1'b0;
      step();
      if (sclk_o) highs++;
    end
    chk("R10 flag ignored", highs, 0);
    blank_n = 1'b1;
    wait_fall();
    wait_rise(); chk("R10 first shift runs", sclk_o, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_div(0);
    t_div(2);
    t_div(5);
    t_blank_gate();
    t_short_blank();
    t_strobe();
    t_split();
    t_split_off();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule